// File: doc/BRIEF.md
# Serial Bus Base Tick Generator

This block derives a slow, evenly spaced timing tick from a fast system clock. A serial bus master uses the tick as its time base; the tick is meant to run at about 1 MHz. The division runs in two stages. An odd-ratio prescaler divides the system clock by 1, 3, 5 or 7. A power-of-two divider then counts the prescaler's output events and divides them by 1 to 128. The whole period is the product of the two ratios, so it is at most 896 system clock cycles.

Software writes a single 8-bit configuration word. The word carries an enable bit and the two ratio selects, and it can be read back at any time. Any write restarts both counters from zero, so a new setting never yields a short or a stretched period. While the enable bit is clear, both counters are held at zero and no tick comes out. The bus master must not start traffic until the block has been configured with the enable set. Choosing the settings that give 1 MHz for a given system clock is the integrator's task.

Top module: `bus_tick_gen`

## Requirements
- R1: While rst_ni is low, the configuration read-back is 0x00 and tick_o is low.
- R2: Configuration bit 7 is the enable, bits 1:0 the prescaler select and bits 4:2 the divider select; bits 6:5 always read back as zero and the other bits read back as written.
- R3: While the enable bit is 0, tick_o stays low.
- R4: The prescaler select value s gives a prescale ratio of 2*s+1 (00 is 1, 01 is 3, 10 is 5, 11 is 7).
- R5: The divider select value d gives a divide ratio of 2 to the power d (000 is 1, through 111 is 128).
- R6: While enabled, tick_o is a one-cycle pulse that repeats every P = prescale ratio times divide ratio system clock cycles.
- R7: After a write that sets the enable, the first tick_o pulse is high in the P-th cycle that follows the write edge.
- R8: Every write restarts both counters, including a write of an unchanged value or a write in mid-period, so no period is shortened or lengthened.
- R9: With the enable set and both selects at zero, tick_o is high on every cycle.
- R10: Clearing the enable resets both counters, so after re-enabling the first tick again comes one full period P later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read-back |
| tick_o | output | 1 | Base time tick, one cycle wide |

## Verification
The bench builds the block with its default widths: a 2-bit prescaler select, a 3-bit divider select and the enable at bit 7 of an 8-bit word. These widths reach every prescale ratio and every divide ratio, including the extreme periods of 1 and 896 cycles. Each run of a setting is scored against tick positions predicted from the write cycle, and a tick at any other cycle is flagged. The bench also makes rewrites in mid-period and toggles the enable, so that a stale counter phase would surface as a misplaced tick.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  localparam int CFG_W_DEF     = 8;
  localparam int EN_BIT_DEF    = 7;
  localparam int PRE_SEL_W_DEF = 2;
  localparam int DIV_SEL_W_DEF = 3;

  // Bits kept by the config register: enable plus both select fields at the bottom.
  function automatic logic [63:0] cfg_keep_mask(input int en_bit, input int field_w);
    logic [63:0] m;
    m = (64'd1 << field_w) - 64'd1;
    m = m | (64'd1 << en_bit);
    return m;
  endfunction
endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick_gen_pkg::*;
#(
  parameter int CFG_W     = CFG_W_DEF,
  parameter int EN_BIT    = EN_BIT_DEF,
  parameter int PRE_SEL_W = PRE_SEL_W_DEF,
  parameter int DIV_SEL_W = DIV_SEL_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output logic [CFG_W-1:0]     rdata_o,
  output logic                 en_o,
  output logic [PRE_SEL_W-1:0] pre_sel_o,
  output logic [DIV_SEL_W-1:0] div_sel_o,
  output logic                 restart_o
);
  localparam int FIELD_W = PRE_SEL_W + DIV_SEL_W;
  localparam int DIV_LSB = PRE_SEL_W;
  localparam logic [63:0] KEEP64 = cfg_keep_mask(EN_BIT, FIELD_W);
  localparam logic [CFG_W-1:0] KEEP = KEEP64[CFG_W-1:0];

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i & KEEP;
  end

  assign rdata_o   = cfg_q;
  assign en_o      = cfg_q[EN_BIT];
  assign pre_sel_o = cfg_q[PRE_SEL_W-1:0];
  assign div_sel_o = cfg_q[DIV_LSB +: DIV_SEL_W];
  // Counters clear on the same edge that loads the new word.
  assign restart_o = we_i;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  // Ratio is 2*sel+1, so the terminal count is 2*sel.
  localparam int CNT_W = SEL_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  assign term    = {sel_i, 1'b0};
  assign at_term = (cnt_q == term);
  assign pulse_o = en_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (at_term)        cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int CNT_W = (2 ** SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  // Terminal count 2**sel - 1: a thermometer of sel ones.
  for (genvar g = 0; g < CNT_W; g++) begin : g_term
    assign term[g] = (sel_i > SEL_W'(g));
  end

  assign at_term = (cnt_q == term);
  assign pulse_o = en_i & step_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (step_i) begin
      if (at_term) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_tick_gen.sv
module bus_tick_gen
  import tick_gen_pkg::*;
#(
  parameter int CFG_W     = CFG_W_DEF,
  parameter int EN_BIT    = EN_BIT_DEF,
  parameter int PRE_SEL_W = PRE_SEL_W_DEF,
  parameter int DIV_SEL_W = DIV_SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             tick_o
);
  logic                 en;
  logic                 restart;
  logic [PRE_SEL_W-1:0] pre_sel;
  logic [DIV_SEL_W-1:0] div_sel;
  logic                 pre_pulse;
  logic                 div_pulse;

  tick_cfg_reg #(
    .CFG_W    (CFG_W),
    .EN_BIT   (EN_BIT),
    .PRE_SEL_W(PRE_SEL_W),
    .DIV_SEL_W(DIV_SEL_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .en_o     (en),
    .pre_sel_o(pre_sel),
    .div_sel_o(div_sel),
    .restart_o(restart)
  );

  tick_prescaler #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .clr_i  (restart),
    .sel_i  (pre_sel),
    .pulse_o(pre_pulse)
  );

  tick_divider #(.SEL_W(DIV_SEL_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .clr_i  (restart),
    .step_i (pre_pulse),
    .sel_i  (div_sel),
    .pulse_o(div_pulse)
  );

  assign tick_o = div_pulse;
endmodule

// File: rtl/bus_tick_gen_chk.sv
module bus_tick_gen_chk #(
  parameter int CFG_W   = 8,
  parameter int EN_BIT  = 7,
  parameter int FIELD_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             tick_o
);
  logic             en;
  logic [FIELD_W-1:0] sel;
  logic               unit_ratio;

  assign en         = cfg_rdata_o[EN_BIT];
  assign sel        = cfg_rdata_o[FIELD_W-1:0];
  assign unit_ratio = (sel == '0);

  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!tick_o && cfg_rdata_o == '0);
  end

  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~((CFG_W'(1) << EN_BIT) | ((CFG_W'(1) << FIELD_W) - CFG_W'(1)))) == '0);

  a_r3_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !tick_o);

  a_r6_single_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !unit_ratio && !cfg_we_i) |=> !tick_o);

  a_r8_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!tick_o || unit_ratio));

  a_r9_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && unit_ratio) |-> tick_o);

  a_r10_reenable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en) && !unit_ratio) |-> !tick_o);
endmodule

bind bus_tick_gen bus_tick_gen_chk #(
  .CFG_W  (CFG_W),
  .EN_BIT (EN_BIT),
  .FIELD_W(PRE_SEL_W + DIV_SEL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_rdata_o(cfg_rdata_o),
  .tick_o     (tick_o)
);

// File: tb/bus_tick_gen_tb.sv
`timescale 1ns/100ps
module bus_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [7:0] wd;
  logic [7:0] rd;
  logic       tick;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    stray = 0;
  bit    done = 1'b0;
  string cur_tag = "R3";

  typedef struct {
    int    at;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  bus_tick_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_wdata_i(wd),
    .cfg_rdata_o(rd),
    .tick_o     (tick)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: compares observed ticks with the expected cycle queue.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
          check(1'b0, {exp_q[0].tag, " missing tick"}, cyc, exp_q[0].at);
          void'(exp_q.pop_front());
        end
        if (tick) begin
          if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
            check(1'b1, exp_q[0].tag, cyc, cyc);
            void'(exp_q.pop_front());
          end else begin
            stray++;
            check(1'b0, {cur_tag, " stray tick at cycle"}, cyc, -1);
          end
        end
      end
    end
  end

  function automatic int period(input logic [7:0] d);
    return (2 * int'(d[1:0]) + 1) << d[4:2];
  endfunction

  // Caller is at a negedge; the write is taken on the next rising edge.
  task automatic do_write(input logic [7:0] d, output int w);
    we = 1'b1;
    wd = d;
    @(negedge clk);
    we = 1'b0;
    w  = cyc;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: writes a setting and queues the predicted tick cycles.
  task automatic run_cfg(input logic [7:0] d, input int n, input string tag);
    int w;
    int p;
    int last;
    cur_tag = tag;
    do_write(d, w);
    p = period(d);
    last = w;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.at = w + p - 1 + k * p;
      e.tag = tag;
      exp_q.push_back(e);
      last = e.at;
    end
    while (cyc < last) @(negedge clk);
  endtask

  initial begin
    int w;
    int s0;
    rst_n = 1'b0;
    we    = 1'b0;
    wd    = '0;
    repeat (3) @(negedge clk);
    check(rd == 8'h00, "R1 readback in reset", rd, 0);
    check(tick == 1'b0, "R1 tick in reset", tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd == 8'h00, "R1 readback after reset", rd, 0);

    // R3: enable clear, selects nonzero
    cur_tag = "R3";
    s0 = stray;
    do_write(8'h0C, w);
    wait_cyc(60);
    do_write(8'h00, w);
    wait_cyc(20);
    check(stray == s0, "R3 ticks while disabled", stray - s0, 0);

    // R2: field positions and zero bits
    cur_tag = "R2";
    do_write(8'hFF, w);
    check(rd == 8'h9F, "R2 readback of 0xFF", rd, 8'h9F);
    do_write(8'h6A, w);
    check(rd == 8'h0A, "R2 readback of 0x6A", rd, 8'h0A);

    // R4: every prescale ratio, divider at 1
    for (int s = 0; s < 4; s++) run_cfg(8'h80 | 8'(s), 4, "R4");
    // R5: every divide ratio, prescaler at 1
    for (int s = 0; s < 8; s++) run_cfg(8'h80 | 8'(s << 2), 3, "R5");
    // R6 / R7: combined ratios, first tick placement
    run_cfg(8'h8E, 3, "R6");
    run_cfg(8'h9F, 2, "R7");
    // R9: unit ratio ticks every cycle
    run_cfg(8'h80, 12, "R9");

    // R8: rewrite of the same value mid-period
    cur_tag = "R8";
    do_write(8'h8D, w);
    wait_cyc(5);
    run_cfg(8'h8D, 2, "R8");
    // R8: new setting mid-period
    cur_tag = "R8";
    do_write(8'h89, w);
    wait_cyc(7);
    run_cfg(8'h86, 2, "R8");

    // R10: disable mid-period then re-enable
    cur_tag = "R10";
    do_write(8'h8D, w);
    wait_cyc(10);
    s0 = stray;
    do_write(8'h0D, w);
    wait_cyc(30);
    check(stray == s0, "R10 ticks while cleared", stray - s0, 0);
    run_cfg(8'h8D, 2, "R10");

    cur_tag = "R3";
    do_write(8'h00, w);
    wait_cyc(10);
    check(exp_q.size() == 0, "R6 pending expected ticks", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule